// File: doc/BRIEF.md
# Event Clock with Coherent Readout and Match Alarm

This block keeps a 24-bit binary count of events arriving on an external tick line. The line is brought into the system clock domain through a small synchroniser, and each rising edge found there adds one to the count. Software reaches the count as three byte-wide registers on a simple access port: a strobe, a write flag, a byte index, and write and read data. A separate select input steers writes either to the count itself or to a write-only 24-bit match value. Reads always return the count.

Three bytes of a running counter cannot be read in one access, so the block holds a snapshot. Reading the top byte copies the whole count into a hold register. Later reads return that copy until the bottom byte has been read, which frees it again. The counter keeps running while the copy is held. Setting the count works the same way in reverse. Writing any count byte halts counting, and only a write to the bottom byte starts it again, so a new time starts from a known value. When an increment brings the count equal to the match value, a one-cycle strobe is raised.

Top module: `evc_event_clock`

## Requirements
- R1: After a synchronous reset the count and the match value are zero, the count is running, no snapshot is held, and `alarm_pulse` is low.
- R2: Each rising edge on `tick_in` adds exactly one to the count while it runs. A level held high counts once. The count is visible at the third clock edge after `tick_in` rises.
- R3: Byte index 0 holds count bits 7-0, index 1 holds bits 15-8, and index 2 holds bits 23-16. Index 3 reads as zero, and writes to it change nothing.
- R4: With `sel_alarm` = 1, writes go to the matching byte of the match value and leave the count untouched. Reads return the count whatever `sel_alarm` is.
- R5: A count write (`sel_alarm` = 0) to index 1 or 2 stores the byte and halts counting. Tick edges are then ignored.
- R6: A count write to index 0 stores the byte and sets the count running.
- R7: A read of index 2 copies the full count into a hold register. Reads of any index then return the held copy, and a re-read of index 2 does not refresh it. A read of index 0 returns the held byte and frees the copy.
- R8: The count keeps advancing while a copy is held. After the copy is freed, reads show the advanced value.
- R9: Reads of index 0 or 1 with no copy held return the live count.
- R10: When an increment makes the count equal to the match value, `alarm_pulse` is high for exactly one cycle, in the cycle the new count is first visible.
- R11: A count write that makes the count equal to the match value raises no `alarm_pulse`.
- R12: The increment carries across byte boundaries, and 0xFFFFFF wraps to 0x000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | Asynchronous event line, counted on rising edges |
| sel_alarm | input | 1 | 1: writes target the match value; 0: writes target the count |
| acc_en | input | 1 | Access strobe, one access per cycle it is high |
| acc_wr | input | 1 | 1: write, 0: read |
| acc_idx | input | 2 | Byte index (0 low, 1 middle, 2 high, 3 unused) |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid combinationally while `acc_en` is high with `acc_wr` low |
| alarm_pulse | output | 1 | One-cycle strobe on an increment that reaches the match value |

## Verification
Counting is tried with short tick pulses, with a level held high, and with start values one below a byte carry and one below wrap-around. These separate a correct edge detector from a level counter and expose a carry that is lost between bytes. Reads are run in three orders: top byte first with ticks arriving during the hold, low byte alone, and a second low-byte read after the hold is freed. These tell a working snapshot from a live read and show that counting goes on in the background. The match value is approached both by a count write and by increments, so a strobe caused by writing is told apart from one caused by counting.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int IDX_W     = 2;
    localparam int BYTE_W    = 8;
    localparam int DEF_CNT_W = 24;

    // One access as seen at the block edge
    typedef struct packed {
        logic              en;
        logic              wr;
        logic              to_alarm;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } acc_req_t;

    // Decoded strobes shared by the submodules
    typedef struct packed {
        logic time_wr;
        logic time_wr_lo;
        logic alarm_wr;
        logic rd_lo;
        logic rd_hi;
    } acc_dec_t;

    function automatic acc_dec_t decode_access(acc_req_t r, int nbytes);
        acc_dec_t d;
        logic     valid;
        valid        = (int'(r.idx) < nbytes);
        d.time_wr    = r.en && r.wr && !r.to_alarm && valid;
        d.time_wr_lo = d.time_wr && (r.idx == '0);
        d.alarm_wr   = r.en && r.wr && r.to_alarm && valid;
        d.rd_lo      = r.en && !r.wr && (r.idx == '0);
        d.rd_hi      = r.en && !r.wr && (int'(r.idx) == nbytes - 1);
        return d;
    endfunction

endpackage

// File: rtl/evc_tick_sync.sv
module evc_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    output logic tick_rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], tick_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign tick_rise = sync_q[SYNC_STAGES-1] && !prev_q;
endmodule

// File: rtl/evc_core.sv
module evc_core
    import evc_pkg::*;
#(
    parameter int COUNT_W = DEF_CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_rise,
    input  acc_req_t           req,
    input  acc_dec_t           dec,
    output logic [COUNT_W-1:0] cnt,
    output logic [COUNT_W-1:0] alarm_val,
    output logic               run,
    output logic               alarm_pulse
);
    localparam int NBYTES = COUNT_W / BYTE_W;

    logic [COUNT_W-1:0] cnt_wr, alarm_wr_val, cnt_inc;
    logic [NBYTES-1:0]  byte_hit;

    // Per-byte merge of the write data into the count and the match value
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign byte_hit[g] = (req.idx == IDX_W'(g));
        assign cnt_wr[g*BYTE_W +: BYTE_W] =
            byte_hit[g] ? req.data : cnt[g*BYTE_W +: BYTE_W];
        assign alarm_wr_val[g*BYTE_W +: BYTE_W] =
            byte_hit[g] ? req.data : alarm_val[g*BYTE_W +: BYTE_W];
    end

    assign cnt_inc = cnt + COUNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            alarm_val   <= '0;
            run         <= 1'b1;
            alarm_pulse <= 1'b0;
        end else begin
            alarm_pulse <= 1'b0;
            if (dec.time_wr) begin
                cnt <= cnt_wr;
                run <= dec.time_wr_lo;
            end else if (tick_rise && run) begin
                cnt         <= cnt_inc;
                alarm_pulse <= (cnt_inc == alarm_val);
            end
            if (dec.alarm_wr) begin
                alarm_val <= alarm_wr_val;
            end
        end
    end
endmodule

// File: rtl/evc_snap.sv
module evc_snap
    import evc_pkg::*;
#(
    parameter int COUNT_W = DEF_CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  acc_dec_t           dec,
    input  logic [COUNT_W-1:0] cnt,
    output logic [COUNT_W-1:0] image,
    output logic [COUNT_W-1:0] snap,
    output logic               hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
            hold <= 1'b0;
        end else if (dec.rd_lo) begin
            hold <= 1'b0;
        end else if (dec.rd_hi && !hold) begin
            snap <= cnt;
            hold <= 1'b1;
        end
    end

    assign image = hold ? snap : cnt;
endmodule

// File: rtl/evc_event_clock.sv
module evc_event_clock
    import evc_pkg::*;
#(
    parameter int COUNT_W     = DEF_CNT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic              sel_alarm,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [BYTE_W-1:0] acc_wdata,
    output logic [BYTE_W-1:0] acc_rdata,
    output logic              alarm_pulse
);
    localparam int NBYTES = COUNT_W / BYTE_W;

    acc_req_t           req;
    acc_dec_t           dec;
    logic               tick_rise;
    logic [COUNT_W-1:0] cnt_q, alarm_q, image, snap_q;
    logic               run_q, hold_q;

    assign req = '{en: acc_en, wr: acc_wr, to_alarm: sel_alarm,
                   idx: acc_idx, data: acc_wdata};
    assign dec = decode_access(req, NBYTES);

    evc_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .tick_in   (tick_in),
        .tick_rise (tick_rise)
    );

    evc_core #(.COUNT_W(COUNT_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .tick_rise   (tick_rise),
        .req         (req),
        .dec         (dec),
        .cnt         (cnt_q),
        .alarm_val   (alarm_q),
        .run         (run_q),
        .alarm_pulse (alarm_pulse)
    );

    evc_snap #(.COUNT_W(COUNT_W)) u_snap (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .cnt   (cnt_q),
        .image (image),
        .snap  (snap_q),
        .hold  (hold_q)
    );

    always_comb begin
        acc_rdata = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (acc_idx == IDX_W'(i)) begin
                acc_rdata = image[i*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
    parameter int COUNT_W = 24
) (
    input logic               clk,
    input logic               rst,
    input logic [COUNT_W-1:0] cnt,
    input logic [COUNT_W-1:0] alarm_val,
    input logic [COUNT_W-1:0] snap,
    input logic               run,
    input logic               hold,
    input logic               time_wr,
    input logic               time_wr_lo,
    input logic               rd_lo,
    input logic               alarm_pulse
);
    // R2: without a count write the count holds or steps by one
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        !time_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + COUNT_W'(1)));

    // R5: a halted count stays put until it is written
    assert_halt_R5: assert property (@(posedge clk) disable iff (rst)
        (!run && !time_wr) |=> $stable(cnt));

    // R5: a write above the low byte halts counting
    assert_stop_R5: assert property (@(posedge clk) disable iff (rst)
        (time_wr && !time_wr_lo) |=> !run);

    // R6: a low-byte write restarts counting
    assert_resume_R6: assert property (@(posedge clk) disable iff (rst)
        time_wr_lo |=> run);

    // R7: a held copy stays frozen until the low byte is read
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (hold && !rd_lo) |=> (hold && $stable(snap)));

    // R7: a low-byte read frees the copy
    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> !hold);

    // R10: the strobe coincides with a count equal to the match value
    assert_match_R10: assert property (@(posedge clk) disable iff (rst)
        alarm_pulse |-> (cnt == alarm_val));

    // R10: the strobe lasts one cycle
    assert_single_R10: assert property (@(posedge clk) disable iff (rst)
        alarm_pulse |=> !alarm_pulse);
endmodule

bind evc_event_clock evc_checker #(.COUNT_W(COUNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt         (cnt_q),
    .alarm_val   (alarm_q),
    .snap        (snap_q),
    .run         (run_q),
    .hold        (hold_q),
    .time_wr     (dec.time_wr),
    .time_wr_lo  (dec.time_wr_lo),
    .rd_lo       (dec.rd_lo),
    .alarm_pulse (alarm_pulse)
);

// File: tb/evc_event_clock_tb.sv
module evc_event_clock_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_in = 1'b0;
    logic       sel_alarm = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_wr = 1'b0;
    logic [1:0] acc_idx = 2'd0;
    logic [7:0] acc_wdata = 8'd0;
    logic [7:0] acc_rdata;
    logic       alarm_pulse;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    evc_event_clock u_dut (
        .clk (clk), .rst (rst), .tick_in (tick_in), .sel_alarm (sel_alarm),
        .acc_en (acc_en), .acc_wr (acc_wr), .acc_idx (acc_idx),
        .acc_wdata (acc_wdata), .acc_rdata (acc_rdata),
        .alarm_pulse (alarm_pulse)
    );

    // Count the cycles the strobe is high, sampled away from the active edge
    always @(negedge clk) if (!rst && alarm_pulse) pulses++;

    task automatic check(string req, int got, int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%06h expected 0x%06h", req, got, exp);
        end
    endtask

    task automatic bus_write(int idx, int data, bit alm);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_idx = 2'(idx);
        acc_wdata = 8'(data); sel_alarm = alm;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; sel_alarm = 1'b0;
    endtask

    task automatic bus_read(int idx, output int val);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_idx = 2'(idx);
        #1 val = int'(acc_rdata);
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic set_time(int v);
        bus_write(2, (v >> 16) & 8'hFF, 1'b0);
        bus_write(1, (v >> 8) & 8'hFF, 1'b0);
        bus_write(0, v & 8'hFF, 1'b0);
    endtask

    task automatic set_alarm(int v);
        bus_write(2, (v >> 16) & 8'hFF, 1'b1);
        bus_write(1, (v >> 8) & 8'hFF, 1'b1);
        bus_write(0, v & 8'hFF, 1'b1);
    endtask

    task automatic read24(output int v);
        int hi, mid, lo;
        bus_read(2, hi);
        bus_read(1, mid);
        bus_read(0, lo);
        v = (hi << 16) | (mid << 8) | lo;
    endtask

    task automatic tick(int high_cycles);
        @(negedge clk);
        tick_in = 1'b1;
        repeat (high_cycles) @(negedge clk);
        tick_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        read24(v);
        check("R1 reset count", v, 0);
        check("R1 reset strobe", pulses, 0);
        bus_read(3, v);
        check("R3 unused index reads zero", v, 0);
        tick(4);
        read24(v);
        check("R1 running after reset", v, 1);
    endtask

    task automatic t_count();
        int v;
        set_time(0);
        for (int i = 0; i < 3; i++) tick(3);
        read24(v);
        check("R2 three edges", v, 3);
        tick(40);
        read24(v);
        check("R2 held level counts once", v, 4);
    endtask

    task automatic t_bytes();
        int v;
        set_time(24'h123456);
        bus_read(0, v); check("R3 R9 low byte", v, 8'h56);
        bus_read(1, v); check("R3 R9 middle byte", v, 8'h34);
        bus_read(2, v); check("R3 high byte", v, 8'h12);
        bus_read(0, v);
        bus_write(3, 8'hAA, 1'b0);
        read24(v);
        check("R3 write to index 3 ignored", v, 24'h123456);
    endtask

    task automatic t_stop();
        int v;
        bus_write(1, 8'h20, 1'b0);
        tick(3); tick(3);
        read24(v);
        check("R5 halted by middle write", v, 24'h122056);
        bus_write(2, 8'h40, 1'b0);
        tick(3);
        read24(v);
        check("R5 halted by high write", v, 24'h402056);
        bus_write(0, 8'h10, 1'b0);
        tick(3);
        read24(v);
        check("R6 low write resumes", v, 24'h402011);
    endtask

    task automatic t_carry();
        int v;
        set_time(24'h00FFFF);
        tick(3);
        read24(v);
        check("R12 carry into high byte", v, 24'h010000);
        set_time(24'hFFFFFF);
        tick(3);
        read24(v);
        check("R12 wrap to zero", v, 0);
    endtask

    task automatic t_latch();
        int v;
        set_time(24'h0000FE);
        bus_read(2, v); check("R7 high byte read", v, 0);
        tick(3); tick(3);
        bus_read(1, v); check("R7 middle from copy", v, 0);
        bus_read(2, v); check("R7 re-read keeps copy", v, 0);
        bus_read(0, v); check("R7 low from copy", v, 8'hFE);
        bus_read(0, v); check("R8 low after release", v, 8'h00);
        bus_read(1, v); check("R8 middle after release", v, 8'h01);
    endtask

    task automatic t_live();
        int a, b;
        set_time(24'h000030);
        bus_read(0, a);
        tick(3);
        bus_read(0, b);
        check("R9 live low byte before", a, 8'h30);
        check("R9 live low byte after", b, 8'h31);
    endtask

    task automatic t_alarm();
        int v, p0;
        set_time(24'h000100);
        set_alarm(24'h000105);
        read24(v);
        check("R4 match writes leave count", v, 24'h000100);
        bus_write(0, 8'h77, 1'b1);
        bus_write(0, 8'h05, 1'b1);
        read24(v);
        check("R4 reads return count", v, 24'h000100);
        p0 = pulses;
        set_time(24'h000105);
        repeat (3) @(negedge clk);
        check("R11 write to match value, no strobe", pulses - p0, 0);
        set_time(24'h000103);
        tick(3);
        check("R10 no strobe below match", pulses - p0, 0);
        tick(3);
        check("R10 one strobe cycle at match", pulses - p0, 1);
        tick(3);
        check("R10 no strobe past match", pulses - p0, 1);
        read24(v);
        check("R10 count past match", v, 24'h000106);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_bytes();
        t_stop();
        t_carry();
        t_latch();
        t_live();
        t_alarm();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got running expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule